// File: doc/BRIEF.md
# Scatter-Gather DMA Channel

This block is a single DMA channel that moves 32-bit words between a host address space and a local address space. Software loads a mode word, a host address, a local address, a byte count and a descriptor pointer through a small register port, then issues a start through a byte-wide command/status register. In single-block mode the channel runs one transfer straight from those registers. In list mode it reads a chain of 16-byte descriptors from memory, runs each element in turn and follows the next pointer until it reaches an element marked as the last.

Descriptors are read, and optionally written back, through a one-word request/grant memory port that has a selector for host or local memory. Data movement is a counted word stream. Each grant on the mover port moves one 4-byte word at the addresses shown on that port, in the direction shown on that port.

Top module: `dma_sg_channel`

## Requirements
- R1: Register select values are 0 mode, 1 host address, 2 local address, 3 byte count, 4 descriptor pointer, 5 command/status. After reset the command/status register reads 0, `irq` is low, and neither `mem_req` nor `mv_req` is asserted.
- R2: With mode bit 9 clear, a command write that has bit 1 (start) and bit 0 (enable) set runs one transfer of ceil(count/4) words. Host address steps by 4 per word. `mv_to_host` equals bit 3 of the pointer register. At the end the count reads 0 and command bit 4 (done) reads 1.
- R3: With mode bit 11 set, the local address stays fixed for the whole transfer. With it clear, the local address steps by 4 per word.
- R4: When mode bit 10 is set, `irq` rises when the channel finishes. A command write with bit 3 set clears `irq`.
- R5: With mode bit 9 set, start fetches the descriptor at pointer bits 31:4 times 16. The memory selector comes from pointer bit 0 (1 = host). Offset 0 loads the host address, offset 4 the local address, offset 8 the count (bits 22:0) and offset 12 the element's own pointer word. Bit 3 of that fetched word sets the element's direction. The chain is followed until a fetched pointer has bit 1 set.
- R6: A fetched pointer word with bit 2 set raises `irq` when its element finishes, even with mode bit 10 clear.
- R7: In list mode with mode bit 16 set, a zero is written to offset 8 of each descriptor once its element completes. With bit 16 clear, descriptors in memory are left unchanged.
- R8: A command write with bit 2 (abort) while busy stops the channel after at most the word granted in that cycle. It sets done, raises `irq` if mode bit 10 is set, and leaves enable reading 1.
- R9: Clearing command bit 0 while busy pauses the channel: no requests are made and no state advances. Setting it again resumes at the next word.
- R10: A start while the channel is busy is ignored. A start written with bit 0 clear is ignored.
- R11: Writes to register selects 0 to 4 are ignored while the channel is busy.
- R12: An element whose count is 0 completes with no data word moved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 3 | Register select for write |
| reg_wdata | input | 32 | Register write data |
| reg_rd_sel | input | 3 | Register select for read |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Interrupt flag |
| mem_req | output | 1 | Descriptor memory request |
| mem_we | output | 1 | Memory request is a write (count clear) |
| mem_in_host | output | 1 | 1 = host memory, 0 = local memory |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_gnt | input | 1 | Memory grant; read data valid in the same cycle |
| mem_rdata | input | 32 | Memory read data |
| mv_req | output | 1 | Data mover request for one word |
| mv_to_host | output | 1 | 1 = local to host, 0 = host to local |
| mv_host_addr | output | 32 | Host address of the current word |
| mv_local_addr | output | 32 | Local address of the current word |
| mv_gnt | input | 1 | Data mover grant; one word moves per granted cycle |

## Verification
The hardest cases to reach are the ones that hit the channel in the middle of a transfer: an abort, a pause, a second start or a register write that arrives while words are still flowing. The bench throttles the mover so that it grants only every other cycle. This stretches a 10-word transfer over enough cycles that these writes can be placed among the grants. The scoreboard queue then shows exactly which words the channel still issued. A three-element chain places its descriptors alternately in host and local memory and mixes directions and a per-link interrupt. This exercises the memory selector, the flags carried in each fetched pointer and the count write-back in one run.

// File: rtl/dma_sg_pkg.sv
package dma_sg_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_MOVE, ST_WBACK} dma_st_e;

    // mode register bit positions
    localparam int MODE_CHAIN   = 9;
    localparam int MODE_DONE_IE = 10;
    localparam int MODE_LHOLD   = 11;
    localparam int MODE_CLRCNT  = 16;

    // pointer word flag positions
    localparam int PTR_IN_HOST  = 0;
    localparam int PTR_LAST     = 1;
    localparam int PTR_LINK_IE  = 2;
    localparam int PTR_TO_HOST  = 3;

    // command/status bit positions
    localparam int CMD_EN       = 0;
    localparam int CMD_START    = 1;
    localparam int CMD_ABORT    = 2;
    localparam int CMD_CLRINT   = 3;
    localparam int CMD_DONE     = 4;

    // register selects
    localparam logic [2:0] SEL_MODE  = 3'd0;
    localparam logic [2:0] SEL_HOST  = 3'd1;
    localparam logic [2:0] SEL_LOCAL = 3'd2;
    localparam logic [2:0] SEL_COUNT = 3'd3;
    localparam logic [2:0] SEL_PTR   = 3'd4;
    localparam logic [2:0] SEL_CMD   = 3'd5;
endpackage

// File: rtl/dma_sg_step.sv
module dma_sg_step #(
    parameter int AW = 32,
    parameter int CW = 23,
    parameter int WB = 4
) (
    input  logic [AW-1:0] haddr_i,
    input  logic [AW-1:0] laddr_i,
    input  logic [CW-1:0] cnt_i,
    input  logic          hold_i,
    output logic [AW-1:0] haddr_o,
    output logic [AW-1:0] laddr_o,
    output logic [CW-1:0] cnt_o
);
    localparam logic [AW-1:0] STEP_A = AW'(WB);
    localparam logic [CW-1:0] STEP_C = CW'(WB);

    always_comb begin
        haddr_o = haddr_i + STEP_A;
        laddr_o = hold_i ? laddr_i : laddr_i + STEP_A;
        cnt_o   = (cnt_i > STEP_C) ? cnt_i - STEP_C : '0;
    end
endmodule

// File: rtl/dma_sg_engine.sv
module dma_sg_engine
    import dma_sg_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 23,
    parameter int WB = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr_en,
    input  logic [2:0]    reg_wr_sel,
    input  logic [AW-1:0] reg_wdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic          mem_in_host,
    output logic [AW-1:0] mem_addr,
    output logic [AW-1:0] mem_wdata,
    input  logic          mem_gnt,
    input  logic [AW-1:0] mem_rdata,
    output logic          mv_req,
    output logic          mv_to_host,
    output logic [AW-1:0] mv_host_addr,
    output logic [AW-1:0] mv_local_addr,
    input  logic          mv_gnt,
    output logic [AW-1:0] mode_o,
    output logic [AW-1:0] haddr_o,
    output logic [AW-1:0] laddr_o,
    output logic [CW-1:0] cnt_o,
    output logic [AW-1:0] ptr_o,
    output logic          en_o,
    output logic          done_o,
    output logic          irq_o
);
    localparam int DBASE_W = AW - 4;

    typedef struct packed {
        dma_st_e              st;
        logic [AW-1:0]        mode;
        logic [AW-1:0]        haddr;
        logic [AW-1:0]        laddr;
        logic [CW-1:0]        cnt;
        logic [AW-1:0]        ptr;
        logic [DBASE_W-1:0]   cur_base;
        logic                 cur_host;
        logic [1:0]           fidx;
        logic                 en;
        logic                 done;
        logic                 irq;
    } chan_t;

    chan_t q, d;
    logic  busy, cmd_wr, chain, elem_end, fin;
    logic [AW-1:0] haddr_n, laddr_n;
    logic [CW-1:0] cnt_n;

    dma_sg_step #(.AW(AW), .CW(CW), .WB(WB)) step_i (
        .haddr_i(q.haddr), .laddr_i(q.laddr), .cnt_i(q.cnt),
        .hold_i(q.mode[MODE_LHOLD]),
        .haddr_o(haddr_n), .laddr_o(laddr_n), .cnt_o(cnt_n)
    );

    assign busy   = (q.st != ST_IDLE);
    assign cmd_wr = reg_wr_en && (reg_wr_sel == SEL_CMD);
    assign chain  = q.mode[MODE_CHAIN];

    assign mem_req       = q.en && (q.st == ST_FETCH || q.st == ST_WBACK);
    assign mem_we        = (q.st == ST_WBACK);
    assign mem_in_host   = q.cur_host;
    assign mem_addr      = {q.cur_base, (q.st == ST_WBACK) ? 2'd2 : q.fidx, 2'b00};
    assign mem_wdata     = '0;
    assign mv_req        = q.en && (q.st == ST_MOVE) && (q.cnt != '0);
    assign mv_to_host    = q.ptr[PTR_TO_HOST];
    assign mv_host_addr  = q.haddr;
    assign mv_local_addr = q.laddr;

    always_comb begin
        d        = q;
        elem_end = 1'b0;
        fin      = 1'b0;
        if (reg_wr_en && !busy) begin
            case (reg_wr_sel)
                SEL_MODE:  d.mode  = reg_wdata;
                SEL_HOST:  d.haddr = reg_wdata;
                SEL_LOCAL: d.laddr = reg_wdata;
                SEL_COUNT: d.cnt   = reg_wdata[CW-1:0];
                SEL_PTR:   d.ptr   = reg_wdata;
                default:   ;
            endcase
        end
        if (cmd_wr) begin
            d.en = reg_wdata[CMD_EN];
            if (reg_wdata[CMD_CLRINT]) d.irq = 1'b0;
        end
        case (q.st)
            ST_IDLE: if (cmd_wr && reg_wdata[CMD_START] && reg_wdata[CMD_EN]) begin
                d.done = 1'b0;
                if (chain) begin
                    d.cur_base = q.ptr[AW-1:4];
                    d.cur_host = q.ptr[PTR_IN_HOST];
                    d.fidx     = 2'd0;
                    d.st       = ST_FETCH;
                end else begin
                    d.st = ST_MOVE;
                end
            end
            ST_FETCH: if (mem_req && mem_gnt) begin
                case (q.fidx)
                    2'd0: d.haddr = mem_rdata;
                    2'd1: d.laddr = mem_rdata;
                    2'd2: d.cnt   = mem_rdata[CW-1:0];
                    default: begin
                        d.ptr = mem_rdata;
                        d.st  = ST_MOVE;
                    end
                endcase
                d.fidx = q.fidx + 2'd1;
            end
            ST_MOVE: if (q.en) begin
                if (q.cnt == '0) begin
                    elem_end = 1'b1;
                end else if (mv_gnt) begin
                    d.haddr = haddr_n;
                    d.laddr = laddr_n;
                    d.cnt   = cnt_n;
                end
            end
            default: if (mem_req && mem_gnt) fin = 1'b1;
        endcase
        if (elem_end) begin
            if (chain && q.mode[MODE_CLRCNT]) d.st = ST_WBACK;
            else                             fin  = 1'b1;
        end
        if (fin) begin
            if (chain && q.ptr[PTR_LINK_IE]) d.irq = 1'b1;
            if (!chain || q.ptr[PTR_LAST]) begin
                d.st   = ST_IDLE;
                d.done = 1'b1;
                if (q.mode[MODE_DONE_IE]) d.irq = 1'b1;
            end else begin
                d.cur_base = q.ptr[AW-1:4];
                d.cur_host = q.ptr[PTR_IN_HOST];
                d.fidx     = 2'd0;
                d.st       = ST_FETCH;
            end
        end
        if (cmd_wr && reg_wdata[CMD_ABORT] && busy) begin
            d.st   = ST_IDLE;
            d.done = 1'b1;
            if (q.mode[MODE_DONE_IE]) d.irq = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mode_o  = q.mode;
    assign haddr_o = q.haddr;
    assign laddr_o = q.laddr;
    assign cnt_o   = q.cnt;
    assign ptr_o   = q.ptr;
    assign en_o    = q.en;
    assign done_o  = q.done;
    assign irq_o   = q.irq;

    p_req_only_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req || mv_req) |-> busy);
    p_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> !busy);
    p_hold_local_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mv_req && mv_gnt && q.mode[MODE_LHOLD]) |=> $stable(q.laddr));
    p_wback_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_wdata == '0 && mem_addr[3:0] == 4'h8 && q.mode[MODE_CLRCNT]));
    p_abort_stops_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && reg_wdata[CMD_ABORT] && busy) |=> (!busy && q.done));
    p_pause_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !q.en && !cmd_wr) |=> ($stable(q.st) && $stable(q.haddr) && $stable(q.cnt)));
    p_busy_write_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_wr_en && reg_wr_sel == SEL_HOST && !(mv_req && mv_gnt) && !(mem_req && mem_gnt))
        |=> $stable(q.haddr));
endmodule

// File: rtl/dma_sg_channel.sv
module dma_sg_channel
    import dma_sg_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 23,
    parameter int WB = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr_en,
    input  logic [2:0]    reg_wr_sel,
    input  logic [AW-1:0] reg_wdata,
    input  logic [2:0]    reg_rd_sel,
    output logic [AW-1:0] reg_rdata,
    output logic          irq,
    output logic          mem_req,
    output logic          mem_we,
    output logic          mem_in_host,
    output logic [AW-1:0] mem_addr,
    output logic [AW-1:0] mem_wdata,
    input  logic          mem_gnt,
    input  logic [AW-1:0] mem_rdata,
    output logic          mv_req,
    output logic          mv_to_host,
    output logic [AW-1:0] mv_host_addr,
    output logic [AW-1:0] mv_local_addr,
    input  logic          mv_gnt
);
    logic [AW-1:0] mode_w, haddr_w, laddr_w, ptr_w;
    logic [CW-1:0] cnt_w;
    logic          en_w, done_w;

    dma_sg_engine #(.AW(AW), .CW(CW), .WB(WB)) eng_i (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel), .reg_wdata(reg_wdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_in_host(mem_in_host),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
        .mv_req(mv_req), .mv_to_host(mv_to_host), .mv_host_addr(mv_host_addr),
        .mv_local_addr(mv_local_addr), .mv_gnt(mv_gnt),
        .mode_o(mode_w), .haddr_o(haddr_w), .laddr_o(laddr_w), .cnt_o(cnt_w),
        .ptr_o(ptr_w), .en_o(en_w), .done_o(done_w), .irq_o(irq)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_rd_sel)
            SEL_MODE:  reg_rdata = mode_w;
            SEL_HOST:  reg_rdata = haddr_w;
            SEL_LOCAL: reg_rdata = laddr_w;
            SEL_COUNT: reg_rdata = AW'(cnt_w);
            SEL_PTR:   reg_rdata = ptr_w;
            SEL_CMD: begin
                reg_rdata[CMD_EN]   = en_w;
                reg_rdata[CMD_DONE] = done_w;
            end
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: tb/dma_sg_channel_tb.sv
`timescale 1ns/1ps
module dma_sg_channel_tb_top;
    logic        clk = 1'b0, rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [2:0]  reg_wr_sel = '0, reg_rd_sel = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        irq, mem_req, mem_we, mem_in_host, mv_req, mv_to_host;
    logic [31:0] mem_addr, mem_wdata, mv_host_addr, mv_local_addr;
    logic        mem_gnt = 1'b0, mv_gnt = 1'b0;
    logic [31:0] mem_rdata = '0;

    always #2.5 clk = ~clk;

    dma_sg_channel dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel),
        .reg_wdata(reg_wdata), .reg_rd_sel(reg_rd_sel), .reg_rdata(reg_rdata), .irq(irq),
        .mem_req(mem_req), .mem_we(mem_we), .mem_in_host(mem_in_host), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
        .mv_req(mv_req), .mv_to_host(mv_to_host), .mv_host_addr(mv_host_addr),
        .mv_local_addr(mv_local_addr), .mv_gnt(mv_gnt)
    );

    typedef struct packed { logic [31:0] h; logic [31:0] l; logic dir; } beat_t;
    beat_t exp_q[$];
    logic [31:0] hmem [64];
    logic [31:0] lmem [64];
    int checks = 0, fails = 0, beats = 0;
    bit slow = 1'b0, tick = 1'b0, finished = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    // memory and mover model plus scoreboard monitor
    always @(negedge clk) begin
        tick = ~tick;
        mem_gnt = 1'b0;
        mv_gnt  = 1'b0;
        if (mem_req) begin
            mem_gnt = 1'b1;
            if (mem_we) begin
                if (mem_in_host) hmem[mem_addr[7:2]] = mem_wdata;
                else             lmem[mem_addr[7:2]] = mem_wdata;
            end else begin
                mem_rdata = mem_in_host ? hmem[mem_addr[7:2]] : lmem[mem_addr[7:2]];
            end
        end
        if (mv_req && (!slow || tick)) begin
            beat_t e;
            mv_gnt = 1'b1;
            beats++;
            if (exp_q.size() == 0) begin
                check(1'b0, "R2", "unexpected word host", mv_host_addr, 32'h0);
            end else begin
                e = exp_q.pop_front();
                check(mv_host_addr == e.h, "R2", "host addr", mv_host_addr, e.h);
                check(mv_local_addr == e.l, "R3", "local addr", mv_local_addr, e.l);
                check(mv_to_host == e.dir, "R5", "direction", {31'b0, mv_to_host}, {31'b0, e.dir});
            end
        end
    end

    task automatic wr(input logic [2:0] sel, input logic [31:0] data);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wdata = data;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] sel, output logic [31:0] val);
        reg_rd_sel = sel;
        #1;
        val = reg_rdata;
    endtask

    task automatic push_elem(input logic [31:0] h, input logic [31:0] l,
                             input int cnt, input logic dir, input logic hold);
        for (int i = 0; i < (cnt + 3) / 4; i++)
            exp_q.push_back('{h: h + 32'(4*i), l: hold ? l : l + 32'(4*i), dir: dir});
    endtask

    task automatic wait_done();
        logic [31:0] v;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            rd(3'd5, v);
            if (v[4]) break;
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "R1", "watchdog expired", 32'h0, 32'h1);
        finish_run();
    end

    initial begin
        logic [31:0] v;
        int b0;
        for (int i = 0; i < 64; i++) begin hmem[i] = '0; lmem[i] = '0; end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(3'd5, v);
        check(v == 32'h0, "R1", "cmd after reset", v, 32'h0);
        check({irq, mem_req, mv_req} == 3'b000, "R1", "irq/req after reset",
              {29'b0, irq, mem_req, mv_req}, 32'h0);

        // R2/R4 single block, increments, done irq, to host
        wr(3'd0, 32'h0000_0400);
        wr(3'd1, 32'h100); wr(3'd2, 32'h200); wr(3'd3, 32'd12); wr(3'd4, 32'h8);
        push_elem(32'h100, 32'h200, 12, 1'b1, 1'b0);
        wr(3'd5, 32'h3);
        wait_done();
        rd(3'd3, v); check(v == 0, "R2", "count at end", v, 0);
        rd(3'd1, v); check(v == 32'h10C, "R2", "host at end", v, 32'h10C);
        rd(3'd2, v); check(v == 32'h20C, "R3", "local incremented", v, 32'h20C);
        check(exp_q.size() == 0, "R2", "words left", exp_q.size(), 0);
        check(irq == 1'b1, "R4", "irq on done", {31'b0, irq}, 1);
        wr(3'd5, 32'h9);
        check(irq == 1'b0, "R4", "irq cleared", {31'b0, irq}, 0);

        // R3 local hold, odd count, no done irq, to local
        wr(3'd0, 32'h0000_0800);
        wr(3'd1, 32'h300); wr(3'd2, 32'h400); wr(3'd3, 32'd10); wr(3'd4, 32'h0);
        push_elem(32'h300, 32'h400, 10, 1'b0, 1'b1);
        wr(3'd5, 32'h3);
        wait_done();
        rd(3'd2, v); check(v == 32'h400, "R3", "local held", v, 32'h400);
        check(exp_q.size() == 0, "R2", "ceil word count", exp_q.size(), 0);
        check(irq == 1'b0, "R4", "no irq without enable", {31'b0, irq}, 0);

        // R5/R6/R7 chain with clear-count, link interrupt
        hmem[16] = 32'h1000; hmem[17] = 32'h2000; hmem[18] = 32'd8;  hmem[19] = 32'h88;
        lmem[32] = 32'h3000; lmem[33] = 32'h4000; lmem[34] = 32'd4;  lmem[35] = 32'hC5;
        hmem[48] = 32'h5000; hmem[49] = 32'h6000; hmem[50] = 32'd12; hmem[51] = 32'h0A;
        push_elem(32'h1000, 32'h2000, 8, 1'b1, 1'b0);
        push_elem(32'h3000, 32'h4000, 4, 1'b0, 1'b0);
        push_elem(32'h5000, 32'h6000, 12, 1'b1, 1'b0);
        wr(3'd0, 32'h0001_0200);
        wr(3'd4, 32'h41);
        wr(3'd5, 32'h3);
        wait_done();
        check(exp_q.size() == 0, "R5", "chain words left", exp_q.size(), 0);
        check(hmem[18] == 0, "R7", "desc0 count cleared", hmem[18], 0);
        check(lmem[34] == 0, "R7", "desc1 count cleared", lmem[34], 0);
        check(hmem[50] == 0, "R7", "desc2 count cleared", hmem[50], 0);
        check(irq == 1'b1, "R6", "link interrupt", {31'b0, irq}, 1);
        rd(3'd4, v); check(v == 32'h0A, "R5", "last pointer loaded", v, 32'h0A);
        wr(3'd5, 32'h9);

        // R7 chain without clear-count keeps memory, no link irq
        hmem[8] = 32'h7000; hmem[9] = 32'h7100; hmem[10] = 32'd8; hmem[11] = 32'h2;
        push_elem(32'h7000, 32'h7100, 8, 1'b0, 1'b0);
        wr(3'd0, 32'h0000_0200);
        wr(3'd4, 32'h21);
        wr(3'd5, 32'h3);
        wait_done();
        check(hmem[10] == 32'd8, "R7", "count kept", hmem[10], 32'd8);
        check(irq == 1'b0, "R6", "no link irq", {31'b0, irq}, 0);
        check(exp_q.size() == 0, "R5", "single-element chain", exp_q.size(), 0);

        // R12 zero count
        b0 = beats;
        wr(3'd0, 32'h0); wr(3'd3, 32'd0);
        wr(3'd5, 32'h3);
        wait_done();
        check(beats == b0, "R12", "no words for zero count", beats, b0);
        rd(3'd5, v); check(v[4] == 1'b1, "R12", "done for zero count", v, 32'h11);

        // R10/R11 start and register writes while busy are ignored
        slow = 1'b1;
        b0 = beats;
        wr(3'd1, 32'h800); wr(3'd2, 32'h900); wr(3'd3, 32'd24); wr(3'd4, 32'h8);
        push_elem(32'h800, 32'h900, 24, 1'b1, 1'b0);
        wr(3'd5, 32'h3);
        repeat (3) @(negedge clk);
        wr(3'd1, 32'hDEAD_0000);
        wr(3'd5, 32'h3);
        wait_done();
        repeat (10) @(negedge clk);
        check(beats - b0 == 6, "R10", "words after restart attempt", beats - b0, 6);
        rd(3'd1, v); check(v == 32'h818, "R11", "host after busy write", v, 32'h818);

        // R10 start with enable clear
        wr(3'd5, 32'h2);
        repeat (5) @(negedge clk);
        rd(3'd5, v);
        check(v == 32'h10, "R10", "start without enable", v, 32'h10);
        check(mv_req == 1'b0, "R10", "no request", {31'b0, mv_req}, 0);

        // R9 pause and resume
        wr(3'd1, 32'hA00); wr(3'd2, 32'hB00); wr(3'd3, 32'd40);
        push_elem(32'hA00, 32'hB00, 40, 1'b1, 1'b0);
        wr(3'd5, 32'h3);
        repeat (4) @(negedge clk);
        wr(3'd5, 32'h0);
        @(negedge clk);
        b0 = beats;
        repeat (20) @(negedge clk);
        check(beats == b0, "R9", "no words while paused", beats, b0);
        check(mv_req == 1'b0, "R9", "request low while paused", {31'b0, mv_req}, 0);
        wr(3'd5, 32'h1);
        wait_done();
        check(exp_q.size() == 0, "R9", "resume completes all", exp_q.size(), 0);

        // R8 abort
        wr(3'd0, 32'h0000_0400);
        wr(3'd1, 32'hC00); wr(3'd2, 32'hD00); wr(3'd3, 32'd40);
        b0 = beats;
        push_elem(32'hC00, 32'hD00, 40, 1'b1, 1'b0);
        wr(3'd5, 32'h3);
        repeat (5) @(negedge clk);
        wr(3'd5, 32'h5);
        wait_done();
        repeat (4) @(negedge clk);
        check(beats - b0 < 10, "R8", "abort stops early", beats - b0, 10);
        rd(3'd5, v); check(v == 32'h11, "R8", "done and enable", v, 32'h11);
        check(irq == 1'b1, "R8", "irq on abort", {31'b0, irq}, 1);
        check(mv_req == 1'b0, "R8", "no request after abort", {31'b0, mv_req}, 0);
        exp_q.delete();

        finish_run();
    end
endmodule